// File: doc/BRIEF.md
# Four-Channel Programmable Baud Tick Generator

This block produces four independent trains of one-cycle clock-enable pulses. A serial receiver or transmitter samples each train at sixteen times its bit rate. Each channel has its own 32-bit configuration word. The word holds an enable flag, a flag that adds a divide-by-16 stage, and a 12-bit reload value. The reload value is the wanted divide ratio minus one, so a 12-bit counter covers ratios 1 to 4096 and the prescale stage extends that to 65536 block-clock cycles per tick.

The reference clock is the block clock itself. A channel runs a small state machine with three states. `CH_OFF` is idle, with the counter and prescaler held at zero. `CH_DIRECT` counts every cycle. `CH_SCALED` counts once every sixteen cycles. The machine moves only when its configuration word is written. Reset enters `CH_OFF`. A write with the enable flag clear gives the transition *park* (any state to `CH_OFF`). A write with the enable flag set and prescale clear gives *run_direct* (any state to `CH_DIRECT`). A write with both flags set gives *run_scaled* (any state to `CH_SCALED`). Every write, including one that stays in the same state, restarts the count from the new settings.

Software writes a word by placing a channel index on the address port and pulsing the write strobe. The addressed channel's stored word is always visible on the read-data port.

Top module: `baud_tick_bank`

## Requirements
- R1: The configuration word layout is: bit 0 selects the divide-by-16 prescale, bits 12:1 hold the reload value D, and bit 16 enables the channel. All other bits are discarded on write and read back as 0. The read-data port shows the stored word of the channel selected by the address port, without a clock delay.
- R2: After reset every configuration word reads 0 and no tick output is ever high.
- R3: In direct mode (enable=1, prescale=0) a channel emits a tick that is high for one cycle every D+1 cycles.
- R4: In prescaled mode (enable=1, prescale=1) a channel emits a one-cycle tick every 16*(D+1) cycles, and never in two consecutive cycles.
- R5: A write restarts the channel. Take the cycle right after the write's clock edge as cycle 0 and let P be the period. The first tick then falls in cycle P-1.
- R6: While the enable bit is clear the channel's tick stays low, and the counter and prescaler are held at zero. A later enabling write therefore again gives the first tick in cycle P-1.
- R7: Address value i selects channel i, for i from 0 to 3. A write to one channel does not disturb the ticks of the others, and all four run at the same time.
- R8: A write that lands in a cycle where the channel's tick is high leaves that tick visible in that cycle. The count then restarts from the new settings, as in R5.
- R9: With D=0 in direct mode the tick is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the reference that is divided |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_addr | input | 2 | Channel index for write and readback |
| cfg_we | input | 1 | Write strobe for the addressed configuration word |
| cfg_wdata | input | 32 | Configuration word to write |
| cfg_rdata | output | 32 | Stored configuration word of the addressed channel |
| tick_o | output | 4 | One-cycle tick per channel |

## Verification
The only two functions that can fall in the same cycle are a channel's reload-and-tick and a software write to that channel. The bench waits until it sees a tick at a falling edge. In that same cycle it drives a write with a new reload value. It then judges two things: the tick must still be observed in that cycle, and the next tick must come after exactly the new period minus one cycles. Sweeps of reload values in both modes on all channels, plus a concurrent four-channel run, check periods against arithmetic computed in the bench.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;
    localparam int WORD_W    = 32;
    localparam int SCALE_BIT = 0;
    localparam int LOAD_LSB  = 1;
    localparam int RUN_BIT   = 16;

    typedef enum logic [1:0] {
        CH_OFF    = 2'd0,
        CH_DIRECT = 2'd1,
        CH_SCALED = 2'd2
    } ch_state_e;
endpackage

// File: rtl/baud_cfg_word.sv
module baud_cfg_word
    import baud_tick_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] word_o,
    output logic [CNT_W-1:0]  reload_o
);
    localparam int LOAD_MSB = LOAD_LSB + CNT_W - 1;

    function automatic logic [WORD_W-1:0] keep_mask();
        logic [WORD_W-1:0] m;
        m = '0;
        m[SCALE_BIT] = 1'b1;
        m[RUN_BIT]   = 1'b1;
        for (int b = LOAD_LSB; b <= LOAD_MSB; b++) m[b] = 1'b1;
        return m;
    endfunction

    localparam logic [WORD_W-1:0] KEEP = keep_mask();

    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    word_q <= '0;
        else if (we_i) word_q <= wdata_i & KEEP;
    end

    assign word_o   = word_q;
    assign reload_o = word_q[LOAD_MSB:LOAD_LSB];

    // R1
    readback_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (word_o == ($past(wdata_i) & KEEP)));
endmodule

// File: rtl/baud_tick_channel.sv
module baud_tick_channel
    import baud_tick_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int PRE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             new_run_i,
    input  logic             new_scale_i,
    input  logic [CNT_W-1:0] new_reload_i,
    input  logic [CNT_W-1:0] cur_reload_i,
    output logic             tick_o
);
    localparam logic [PRE_W-1:0] PRE_LAST = {PRE_W{1'b1}};

    ch_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [PRE_W-1:0] pre_q;
    logic             step;

    // Next-state logic: moves only on a write
    always_comb begin
        state_d = state_q;
        if (load_i) begin
            if (!new_run_i)      state_d = CH_OFF;
            else if (new_scale_i) state_d = CH_SCALED;
            else                 state_d = CH_DIRECT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_OFF;
        else        state_q <= state_d;
    end

    // Output logic per state
    always_comb begin
        unique case (state_q)
            CH_OFF:    step = 1'b0;
            CH_DIRECT: step = 1'b1;
            CH_SCALED: step = (pre_q == PRE_LAST);
            default:   step = 1'b0;
        endcase
        tick_o = step && (cnt_q == '0);
    end

    // Counter and prescaler datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            pre_q <= '0;
        end else if (load_i) begin
            cnt_q <= new_run_i ? new_reload_i : '0;
            pre_q <= '0;
        end else begin
            unique case (state_q)
                CH_OFF: begin
                    cnt_q <= '0;
                    pre_q <= '0;
                end
                CH_DIRECT: begin
                    pre_q <= '0;
                    cnt_q <= (cnt_q == '0) ? cur_reload_i : cnt_q - 1'b1;
                end
                CH_SCALED: begin
                    pre_q <= pre_q + 1'b1;
                    if (step) cnt_q <= (cnt_q == '0) ? cur_reload_i : cnt_q - 1'b1;
                end
                default: begin
                    cnt_q <= '0;
                    pre_q <= '0;
                end
            endcase
        end
    end

    // R6
    off_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_OFF) |-> (cnt_q == '0 && pre_q == '0 && !tick_o));

    // R3
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= cur_reload_i);

    // R4
    scaled_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_SCALED && tick_o && !load_i) |=> !tick_o);

    // R9
    every_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_DIRECT && cur_reload_i == '0) |-> tick_o);

    // R8
    write_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && new_run_i) |=> (cnt_q == $past(new_reload_i) && pre_q == '0));
endmodule

// File: rtl/baud_tick_bank.sv
module baud_tick_bank
    import baud_tick_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 12,
    parameter int PRE_W  = 4,
    localparam int ADDR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_we,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic [WORD_W-1:0] cfg_rdata,
    output logic [NUM_CH-1:0] tick_o
);
    localparam int LOAD_MSB = LOAD_LSB + CNT_W - 1;

    logic [NUM_CH-1:0][WORD_W-1:0] word_all;
    logic [NUM_CH-1:0][CNT_W-1:0]  reload_all;
    logic [NUM_CH-1:0]             load_sel;

    wire              w_run    = cfg_wdata[RUN_BIT];
    wire              w_scale  = cfg_wdata[SCALE_BIT];
    wire [CNT_W-1:0]  w_reload = cfg_wdata[LOAD_MSB:LOAD_LSB];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign load_sel[g] = cfg_we && (cfg_addr == ADDR_W'(g));

        baud_cfg_word #(.CNT_W(CNT_W)) cfg_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .we_i     (load_sel[g]),
            .wdata_i  (cfg_wdata),
            .word_o   (word_all[g]),
            .reload_o (reload_all[g])
        );

        baud_tick_channel #(.CNT_W(CNT_W), .PRE_W(PRE_W)) ch_i (
            .clk          (clk),
            .rst_n        (rst_n),
            .load_i       (load_sel[g]),
            .new_run_i    (w_run),
            .new_scale_i  (w_scale),
            .new_reload_i (w_reload),
            .cur_reload_i (reload_all[g]),
            .tick_o       (tick_o[g])
        );

        // R6
        tick_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tick_o[g] |-> word_all[g][RUN_BIT]);
    end

    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (cfg_addr == ADDR_W'(i)) cfg_rdata = word_all[i];
        end
    end

    // R7
    single_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load_sel));
endmodule

// File: tb/baud_tick_bank_tb_top.sv
module baud_tick_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [3:0]  tick_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    baud_tick_bank dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_addr  (cfg_addr),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .tick_o    (tick_o)
    );

    function automatic logic [31:0] mk(bit run, bit scale, int d);
        logic [31:0] w;
        w = '0;
        w[16] = run;
        w[0]  = scale;
        w[12:1] = d[11:0];
        return w;
    endfunction

    task automatic check(string req, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // drive a write in the current cycle; returns at the next falling edge (cycle 0)
    task automatic write_here(int ch, logic [31:0] d);
        cfg_we = 1'b1;
        cfg_addr = 2'(ch);
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_write(int ch, logic [31:0] d);
        @(negedge clk);
        write_here(ch, d);
    endtask

    task automatic meas(int ch, int lim, output int k);
        k = 0;
        while (!tick_o[ch] && k < lim) begin
            @(negedge clk);
            k++;
        end
    endtask

    // R5 latency then R3/R4 period
    task automatic sweep_one(int ch, bit scale, int d, string req);
        int p, k;
        p = scale ? 16 * (d + 1) : (d + 1);
        cfg_write(ch, mk(1'b1, scale, d));
        meas(ch, p + 4, k);
        check("R5", k, p - 1);
        @(negedge clk);
        check(req, tick_o[ch], (p == 1) ? 1 : 0);
        meas(ch, p + 4, k);
        check(req, k + 1, p);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int k;
        int cnt [4];
        int per [4];
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state
        for (int c = 0; c < 4; c++) begin
            cfg_addr = 2'(c);
            #1;
            check("R2", cfg_rdata, 0);
        end
        k = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (tick_o != 4'b0) k++;
        end
        check("R2", k, 0);

        // R1 field mask and readback
        cfg_write(1, 32'hFFFF_FFFF);
        cfg_addr = 2'd1;
        #1;
        check("R1", cfg_rdata, 32'h0001_1FFF);
        cfg_write(2, 32'hA5A5_5A5A);
        cfg_addr = 2'd2;
        #1;
        check("R1", cfg_rdata, 32'hA5A5_5A5A & 32'h0001_1FFF);
        cfg_addr = 2'd1;
        #1;
        check("R7", cfg_rdata, 32'h0001_1FFF);
        for (int c = 0; c < 4; c++) cfg_write(c, 32'h0);

        // R3 / R4 / R9 sweeps on every channel
        for (int c = 0; c < 4; c++) begin
            sweep_one(c, 1'b0, 0, "R9");
            sweep_one(c, 1'b0, 1, "R3");
            sweep_one(c, 1'b0, 2, "R3");
            sweep_one(c, 1'b0, 5, "R3");
            sweep_one(c, 1'b0, 17, "R3");
            sweep_one(c, 1'b0, 100, "R3");
            sweep_one(c, 1'b1, 0, "R4");
            sweep_one(c, 1'b1, 1, "R4");
            sweep_one(c, 1'b1, 3, "R4");
            sweep_one(c, 1'b1, 10, "R4");
            cfg_write(c, 32'h0);
        end
        sweep_one(0, 1'b0, 4095, "R3");
        cfg_write(0, 32'h0);

        // R6 disable holds low, re-enable restarts from zero
        cfg_write(2, mk(1'b1, 1'b0, 2));
        repeat (7) @(negedge clk);
        cfg_write(2, mk(1'b0, 1'b0, 2));
        k = 0;
        for (int i = 0; i < 50; i++) begin
            if (tick_o[2]) k++;
            @(negedge clk);
        end
        check("R6", k, 0);
        cfg_write(2, mk(1'b1, 1'b1, 1));
        meas(2, 40, k);
        check("R6", k, 31);
        cfg_write(2, 32'h0);

        // R8 write landing on a tick cycle
        cfg_write(0, mk(1'b1, 1'b0, 3));
        meas(0, 10, k);
        check("R8", k, 3);
        check("R8", tick_o[0], 1);
        write_here(0, mk(1'b1, 1'b0, 6));
        meas(0, 12, k);
        check("R8", k, 6);
        cfg_write(0, 32'h0);

        // R7 four channels at once
        per[0] = 5; per[1] = 16; per[2] = 7; per[3] = 48;
        @(negedge clk);
        write_here(0, mk(1'b1, 1'b0, 4));
        write_here(1, mk(1'b1, 1'b1, 0));
        write_here(2, mk(1'b1, 1'b0, 6));
        write_here(3, mk(1'b1, 1'b1, 2));
        for (int c = 0; c < 4; c++) cnt[c] = 0;
        for (int i = 0; i < 500; i++) begin
            for (int c = 0; c < 4; c++) if (tick_o[c]) cnt[c]++;
            @(negedge clk);
        end
        for (int c = 0; c < 4; c++) begin
            int st;
            st = 3 - c;
            check("R7", cnt[c], (st + 500) / per[c] - st / per[c]);
        end
        for (int c = 0; c < 4; c++) cfg_write(c, 32'h0);

        // R4 longest prescaled ratio
        sweep_one(3, 1'b1, 4095, "R4");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule